// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the internal word address of a synchronous burst memory. A cycle marked as a load takes a new external address and starts a burst. A cycle marked as an advance moves the burst on by one beat. Only the low burst-offset bits change from beat to beat, and the upper bits keep the value taken at load. A static order input chooses the sequence of the low bits. In linear order they count up and wrap. In interleaved order the beat number is XORed with the offset that was loaded.

A clock-enable input freezes the whole block when it is low. A chip-enable input, sampled only on load cycles, decides whether the load starts a burst or deselects the block. The read-or-write type given at load is carried through every beat of the burst. The outputs come straight from registers and the low-bit mapping, so a load or an advance shows at the outputs in the cycle after the edge that samples it.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset is released, `burst_active` is 0, `word_addr` is all zeros and `burst_is_write` is 0.
- R2: On an edge with `clk_en`=1, `adv_n_load`=0 and `chip_en`=1, the next cycle shows `word_addr` equal to the sampled `ext_addr`, `burst_active`=1 and `burst_is_write` equal to the sampled `op_write`.
- R3: With `order_interleave`=0, after n advance edges following a load with low offset s, the two low bits of `word_addr` equal (s+n) mod 4.
- R4: With `order_interleave`=1, after n advance edges following a load with low offset s, the two low bits of `word_addr` equal s XOR (n mod 4).
- R5: During advances, bits above bit 1 of `word_addr` stay equal to the upper bits that were loaded.
- R6: After four advances the address returns to the loaded address, and later advances repeat the same four-address cycle.
- R7: On an edge with `clk_en`=0, all outputs keep their values, whatever the other inputs are.
- R8: On an edge with `clk_en`=1, `adv_n_load`=0 and `chip_en`=0, `burst_active` becomes 0 and `word_addr` and `burst_is_write` keep their values.
- R9: An advance edge while `burst_active`=0 leaves every output unchanged.
- R10: During advances, `burst_is_write` keeps the type taken at load, and `op_write` and `chip_en` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock qualifier; 0 freezes all state |
| chip_en | input | 1 | Select, sampled on load cycles |
| adv_n_load | input | 1 | 1 = advance burst, 0 = load address |
| order_interleave | input | 1 | 0 = linear order, 1 = interleaved order |
| op_write | input | 1 | Operation type at load, 1 = write |
| ext_addr | input | ADDR_W | External address, sampled on load |
| word_addr | output | ADDR_W | Internal address to the array |
| burst_is_write | output | 1 | Type of the burst in progress |
| burst_active | output | 1 | A selected burst is in progress |

## Verification
The bench runs every start offset in both orders, with more than four advances, so it sees the wrap. A sequencer that carried out of bit 1, or that added in interleaved mode, would show wrong addresses or changed upper bits there. The bench also checks load cycles that deselect, advances with no burst active, and frozen cycles that offer conflicting inputs. These catch a design that keeps counting while stalled or that takes a new operation type in the middle of a burst.

// File: rtl/burst_addr_seq_pkg.sv
package burst_addr_seq_pkg;

    typedef struct packed {
        logic        active;
        logic        is_write;
        logic [1:0]  beat;
    } seq_ctl_t;

endpackage

// File: rtl/burst_offset_map.sv
module burst_offset_map #(
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] start_ofs,
    input  logic [OFS_W-1:0] beat,
    input  logic             interleave,
    output logic [OFS_W-1:0] ofs_out
);
    logic [OFS_W-1:0] lin_ofs;
    logic [OFS_W-1:0] xor_ofs;

    assign lin_ofs = start_ofs + beat;

    for (genvar b = 0; b < OFS_W; b++) begin : g_xor
        assign xor_ofs[b] = start_ofs[b] ^ beat[b];
    end

    assign ofs_out = interleave ? xor_ofs : lin_ofs;
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_addr_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              chip_en,
    input  logic              adv_n_load,
    input  logic              op_write,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base_q,
    output seq_ctl_t          ctl_q
);
    seq_ctl_t          ctl_d;
    logic [ADDR_W-1:0] base_d;

    always_comb begin
        ctl_d  = ctl_q;
        base_d = base_q;
        if (clk_en) begin
            if (!adv_n_load) begin
                if (chip_en) begin
                    base_d       = ext_addr;
                    ctl_d.beat   = '0;
                    ctl_d.active = 1'b1;
                    ctl_d.is_write = op_write;
                end else begin
                    ctl_d.active = 1'b0;
                end
            end else if (ctl_q.active) begin
                ctl_d.beat = ctl_q.beat + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            base_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            base_q <= base_d;
        end
    end

    // R7: a stalled edge changes nothing
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(ctl_q) && $stable(base_q)));

    // R2: a selected load restarts the beat count and captures the address
    a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_n_load && chip_en) |=>
            (ctl_q.active && ctl_q.beat == 2'd0 && base_q == $past(ext_addr)));

    // R8: a deselecting load ends the burst
    a_r8_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_n_load && !chip_en) |=> (!ctl_q.active && $stable(base_q)));

    // R9: advancing with no burst leaves state alone
    a_r9_idle_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_n_load && !ctl_q.active) |=> ($stable(ctl_q) && $stable(base_q)));

    // R10: operation type is kept through advances
    a_r10_type_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_n_load) |=> $stable(ctl_q.is_write));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_addr_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              chip_en,
    input  logic              adv_n_load,
    input  logic              order_interleave,
    input  logic              op_write,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] word_addr,
    output logic              burst_is_write,
    output logic              burst_active
);
    localparam int OFS_W = 2;

    logic [ADDR_W-1:0] base_q;
    seq_ctl_t          ctl_q;
    logic [OFS_W-1:0]  low_ofs;

    burst_seq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .chip_en    (chip_en),
        .adv_n_load (adv_n_load),
        .op_write   (op_write),
        .ext_addr   (ext_addr),
        .base_q     (base_q),
        .ctl_q      (ctl_q)
    );

    burst_offset_map #(.OFS_W(OFS_W)) map_i (
        .start_ofs  (base_q[OFS_W-1:0]),
        .beat       (ctl_q.beat),
        .interleave (order_interleave),
        .ofs_out    (low_ofs)
    );

    assign word_addr      = {base_q[ADDR_W-1:OFS_W], low_ofs};
    assign burst_is_write = ctl_q.is_write;
    assign burst_active   = ctl_q.active;

    // R5: advances never disturb the upper address bits
    a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_n_load) |=> $stable(word_addr[ADDR_W-1:OFS_W]));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic          chip_en = 1'b0;
    logic          adv_n_load = 1'b1;
    logic          order_interleave = 1'b0;
    logic          op_write = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] word_addr;
    logic          burst_is_write;
    logic          burst_active;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_en(chip_en),
        .adv_n_load(adv_n_load), .order_interleave(order_interleave),
        .op_write(op_write), .ext_addr(ext_addr), .word_addr(word_addr),
        .burst_is_write(burst_is_write), .burst_active(burst_active)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic ce_clk, input logic adv, input logic ce, input logic wr,
                       input logic [AW-1:0] a);
        clk_en = ce_clk; adv_n_load = adv; chip_en = ce; op_write = wr; ext_addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [AW-1:0] held;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", word_addr, '0);
        chk("R1", AW'(burst_active), '0);
        chk("R1", AW'(burst_is_write), '0);
        rst_n = 1'b1;
        cyc(1, 1, 1, 1, '1);
        // R9: advance with no burst changes nothing
        chk("R9", word_addr, '0);
        chk("R9", AW'(burst_active), '0);

        // R3/R4/R5/R6 sweep: both orders, all offsets, two upper patterns
        for (int m = 0; m < 2; m++) begin
            for (int up = 0; up < 2; up++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [AW-1:0] a;
                    logic wr;
                    a = (up == 0) ? AW'((17'h0ABC << 2) | s) : AW'(((AW'(1) << AW) - 4) | s);
                    wr = (s[0] ^ up[0]);
                    order_interleave = m[0];
                    cyc(1, 0, 1, wr, a);
                    chk("R2", word_addr, a);
                    chk("R2", AW'(burst_active), 1);
                    chk("R2", AW'(burst_is_write), AW'(wr));
                    for (int n = 1; n <= 9; n++) begin
                        logic [1:0] lo;
                        cyc(1, 1, n[0], ~wr, ~a);
                        lo = m[0] ? (2'(s) ^ 2'(n)) : 2'(s + n);
                        chk(m[0] ? "R4" : "R3", AW'(word_addr[1:0]), AW'(lo));
                        chk("R5", word_addr >> 2, a >> 2);
                        chk("R10", AW'(burst_is_write), AW'(wr));
                        if (n % 4 == 0) chk("R6", word_addr, a);
                    end
                end
            end
        end

        // R7: stall holds everything under conflicting inputs
        order_interleave = 1'b0;
        cyc(1, 0, 1, 1, 17'h00105);
        cyc(1, 1, 0, 0, '0);
        held = word_addr;
        chk("R3", held, 17'h00106);
        for (int k = 0; k < 4; k++) begin
            cyc(0, k[0], k[1], k[0], 17'h1F0F0);
            chk("R7", word_addr, held);
            chk("R7", AW'(burst_active), 1);
            chk("R7", AW'(burst_is_write), 1);
        end
        // R8: deselecting load
        cyc(1, 0, 0, 0, 17'h0FFFF);
        chk("R8", AW'(burst_active), 0);
        chk("R8", word_addr, held);
        chk("R8", AW'(burst_is_write), 1);
        // R9: advances after deselect do nothing
        cyc(1, 1, 1, 0, '0);
        cyc(1, 1, 0, 0, '0);
        chk("R9", word_addr, held);
        chk("R9", AW'(burst_active), 0);
        // R7: stalled load does not start a burst
        cyc(0, 0, 1, 0, 17'h00002);
        chk("R7", AW'(burst_active), 0);
        chk("R7", word_addr, held);

        done = 1;
        finish_run();
    end
endmodule